// File: doc/BRIEF.md
# Prioritized Fault Duty-Cycle Indicator

This block drives one active-low fault pin when the chip runs without a host bus. It takes five fault flags, one each for the gate rails, the source rails together with the boost node, the common-voltage buffer, the memory and thermal shutdown. It picks the most severe active flag and shows it as a pulse train on the pin. All pulse classes share one period. The fraction of each period that the pin is held low tells which class of fault is being shown. The most severe faults hold the pin low all the time. With no fault, the pin stays released.

The period is built from a timebase strobe `tick_en`. A divider counts `QUARTER_TICKS` strobes per quarter-period, and a 2-bit slot counter steps through the four quarters of each period. With a 1 MHz strobe and the default `QUARTER_TICKS` of 250, the period is 1 ms, which gives the 1 kHz pin rate. The class on display is sampled only when a period ends, so every period on the pin is one complete waveform of a single class. Detection of the faults is not part of this block. The pin is a plain status output with no handshake, so the block has no valid/ready interface and no back-pressure rules.

Top module: `fault_duty_ind`

## Requirements
- R1: After reset the pin is high. The timebase starts at quarter 0, count 0, and the displayed class is "none".
- R2: While the displayed class is "none", the pin is high for the whole period.
- R3: A gate-rail fault (`flt_gate`) is shown as low in quarters 0, 1 and 2 and high in quarter 3, which is 75% low.
- R4: A source-rail or boost-node fault (`flt_src`) is shown as low in quarters 0 and 1 and high in quarters 2 and 3, which is 50% low.
- R5: A common-voltage buffer fault (`flt_buf`) is shown as low in quarter 0 only, which is 25% low.
- R6: A memory fault (`flt_mem`) or a thermal shutdown (`flt_therm`) holds the pin low in all four quarters.
- R7: When several flags are high, only the most severe class is shown. Severity from lowest to highest is: gate rail, source rail, buffer, then memory or thermal.
- R8: The displayed class changes only at a period boundary. A boundary is the enabled strobe that ends quarter 3. The new class is taken from the flags present on that strobe.
- R9: Each quarter lasts `QUARTER_TICKS` clock cycles in which `tick_en` is high. Cycles with `tick_en` low leave the timebase and the pin unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timebase strobe. The divider advances on cycles where it is high |
| flt_gate | input | 1 | Gate-rail fault flag |
| flt_src | input | 1 | Source-rail or boost-node fault flag |
| flt_buf | input | 1 | Common-voltage buffer fault flag |
| flt_mem | input | 1 | Memory fault flag |
| flt_therm | input | 1 | Thermal shutdown flag |
| pin_n | output | 1 | Active-low fault pin drive |

## Verification
Each fault flag is first applied alone, including thermal and memory separately. This checks that each class produces its own number of low quarters. Flags are then applied in overlapping combinations, which shows that a lower-severity flag cannot change what a higher one displays. Flags are also switched at odd offsets inside a period, which separates a design that updates at the boundary from one that updates at once. Finally, irregular and long-gated `tick_en` patterns confirm that only enabled strobes move the waveform forward.

// File: rtl/fdi_pkg.sv
package fdi_pkg;
  typedef enum logic [2:0] {
    CLS_NONE  = 3'd0,
    CLS_GATE  = 3'd1,
    CLS_SRC   = 3'd2,
    CLS_BUF   = 3'd3,
    CLS_SOLID = 3'd4
  } fault_cls_e;

  localparam int unsigned QUARTERS = 4;

  // Number of low quarters per period for each class.
  function automatic logic [2:0] low_quarters(input fault_cls_e c);
    case (c)
      CLS_GATE:  return 3'd3;
      CLS_SRC:   return 3'd2;
      CLS_BUF:   return 3'd1;
      CLS_SOLID: return 3'd4;
      default:   return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/fdi_prio_enc.sv
module fdi_prio_enc
  import fdi_pkg::*;
(
  input  logic       flt_gate,
  input  logic       flt_src,
  input  logic       flt_buf,
  input  logic       flt_mem,
  input  logic       flt_therm,
  output fault_cls_e cls
);
  always_comb begin
    if (flt_mem || flt_therm) cls = CLS_SOLID;
    else if (flt_buf)         cls = CLS_BUF;
    else if (flt_src)         cls = CLS_SRC;
    else if (flt_gate)        cls = CLS_GATE;
    else                      cls = CLS_NONE;
  end
endmodule

// File: rtl/fdi_timebase.sv
module fdi_timebase #(
  parameter int unsigned QUARTER_TICKS = 250,
  localparam int unsigned CNT_W = (QUARTER_TICKS > 1) ? $clog2(QUARTER_TICKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  output logic [1:0]       slot,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(QUARTER_TICKS - 1);

  logic quarter_end;
  assign quarter_end = tick_en && (cnt == CNT_LAST);
  assign wrap        = quarter_end && (slot == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      slot <= 2'd0;
    end else if (quarter_end) begin
      cnt  <= '0;
      slot <= slot + 2'd1;
    end else if (tick_en) begin
      cnt  <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/fdi_wave.sv
module fdi_wave
  import fdi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wrap,
  input  fault_cls_e cls_in,
  input  logic [1:0] slot,
  output fault_cls_e cls_q,
  output logic       pin_n
);
  logic [QUARTERS-1:0] low_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cls_q <= CLS_NONE;
    else if (wrap) cls_q <= cls_in;
  end

  // One mask bit per quarter: low while the quarter index is under the class's count.
  for (genvar q = 0; q < QUARTERS; q++) begin : g_q
    assign low_mask[q] = (3'(q) < low_quarters(cls_q));
  end

  assign pin_n = ~low_mask[slot];
endmodule

// File: rtl/fault_duty_ind.sv
module fault_duty_ind
  import fdi_pkg::*;
#(
  parameter int unsigned QUARTER_TICKS = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic flt_gate,
  input  logic flt_src,
  input  logic flt_buf,
  input  logic flt_mem,
  input  logic flt_therm,
  output logic pin_n
);
  localparam int unsigned CNT_W = (QUARTER_TICKS > 1) ? $clog2(QUARTER_TICKS) : 1;

  fault_cls_e       cls_now;
  fault_cls_e       cls_q;
  logic [1:0]       slot;
  logic [CNT_W-1:0] cnt;
  logic             wrap;

  fdi_prio_enc u_enc (
    .flt_gate (flt_gate),
    .flt_src  (flt_src),
    .flt_buf  (flt_buf),
    .flt_mem  (flt_mem),
    .flt_therm(flt_therm),
    .cls      (cls_now)
  );

  fdi_timebase #(.QUARTER_TICKS(QUARTER_TICKS)) u_tb (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_en(tick_en),
    .slot   (slot),
    .cnt    (cnt),
    .wrap   (wrap)
  );

  fdi_wave u_wave (
    .clk   (clk),
    .rst_n (rst_n),
    .wrap  (wrap),
    .cls_in(cls_now),
    .slot  (slot),
    .cls_q (cls_q),
    .pin_n (pin_n)
  );
endmodule

// File: rtl/fault_duty_ind_chk.sv
module fault_duty_ind_chk
  import fdi_pkg::*;
#(
  parameter int unsigned QUARTER_TICKS = 250,
  localparam int unsigned CNT_W = (QUARTER_TICKS > 1) ? $clog2(QUARTER_TICKS) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             flt_gate,
  input logic             flt_src,
  input logic             flt_buf,
  input logic             flt_mem,
  input logic             flt_therm,
  input logic             pin_n,
  input logic [1:0]       slot,
  input logic [CNT_W-1:0] cnt,
  input fault_cls_e       cls_q
);
  logic at_edge;
  assign at_edge = tick_en && (slot == 2'd3) && (cnt == CNT_W'(QUARTER_TICKS - 1));

  // R9
  freeze_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> ($stable(slot) && $stable(cnt) && $stable(pin_n)));

  // R8
  class_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !at_edge |=> $stable(cls_q));

  // R7
  severe_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_edge && (flt_mem || flt_therm)) |=> (cls_q == CLS_SOLID));

  // R2
  idle_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_edge && !(flt_gate || flt_src || flt_buf || flt_mem || flt_therm)) |=> (cls_q == CLS_NONE));

  // R6
  solid_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_q == CLS_SOLID) |-> !pin_n);

  // R2
  released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_q == CLS_NONE) |-> pin_n);

  // R3
  gate_last_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_q == CLS_GATE) |-> (pin_n == (slot == 2'd3)));
endmodule

bind fault_duty_ind fault_duty_ind_chk #(.QUARTER_TICKS(QUARTER_TICKS)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_en  (tick_en),
  .flt_gate (flt_gate),
  .flt_src  (flt_src),
  .flt_buf  (flt_buf),
  .flt_mem  (flt_mem),
  .flt_therm(flt_therm),
  .pin_n    (pin_n),
  .slot     (slot),
  .cnt      (cnt),
  .cls_q    (cls_q)
);

// File: tb/fault_duty_ind_tb_top.sv
module fault_duty_ind_tb_top;
  localparam int QT  = 5;
  localparam int PER = 4 * QT;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0;
  logic f_gate = 1'b0, f_src = 1'b0, f_buf = 1'b0, f_mem = 1'b0, f_therm = 1'b0;
  logic pin_n;

  int total = 0;
  int bad = 0;
  string req = "R1";

  // Reference model state
  int ticks = 0;
  int shown = 0; // 0 none, 1 gate, 2 src, 3 buf, 4 solid

  always #4 clk = ~clk;

  fault_duty_ind #(.QUARTER_TICKS(QT)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .flt_gate(f_gate), .flt_src(f_src), .flt_buf(f_buf),
    .flt_mem(f_mem), .flt_therm(f_therm), .pin_n(pin_n)
  );

  function automatic int worst();
    if (f_mem || f_therm) return 4;
    if (f_buf) return 3;
    if (f_src) return 2;
    if (f_gate) return 1;
    return 0;
  endfunction

  function automatic int lows(int c);
    int tbl[5] = '{0, 3, 2, 1, 4};
    return tbl[c];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ticks = 0;
      shown = 0;
    end else if (tick_en) begin
      if (ticks == PER - 1) begin
        ticks = 0;
        shown = worst();
      end else begin
        ticks = ticks + 1;
      end
    end
  end

  task automatic check_pin();
    logic exp_pin;
    exp_pin = !((ticks / QT) < lows(shown));
    total++;
    if (pin_n !== exp_pin) begin
      bad++;
      $display("FAIL %s: t=%0t pin_n actual=%b expected=%b", req, $time, pin_n, exp_pin);
    end
  endtask

  task automatic run(int n, int mode);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_pin();
      case (mode)
        0: tick_en = 1'b1;
        1: tick_en = (i % 3) != 0;
        default: tick_en = 1'b0;
      endcase
    end
  endtask

  task automatic set_f(logic g, logic s, logic b, logic m, logic t);
    f_gate = g; f_src = s; f_buf = b; f_mem = m; f_therm = t;
  endtask

  initial begin
    #200000;
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    req = "R1";
    check_pin();
    total++;
    if (pin_n !== 1'b1) begin
      bad++;
      $display("FAIL R1: reset pin_n actual=%b expected=1", pin_n);
    end
    rst_n = 1'b1;
    req = "R2";  run(2 * PER, 0);
    req = "R3";  set_f(1, 0, 0, 0, 0); run(3 * PER, 0);
    req = "R4";  set_f(0, 1, 0, 0, 0); run(3 * PER + 7, 0);
    req = "R5";  set_f(0, 0, 1, 0, 0); run(3 * PER, 0);
    req = "R6";  set_f(0, 0, 0, 1, 0); run(2 * PER + 3, 0);
    req = "R6";  set_f(0, 0, 0, 0, 1); run(2 * PER, 0);
    req = "R7";  set_f(1, 1, 1, 0, 0); run(2 * PER, 0);
    req = "R7";  set_f(1, 1, 0, 0, 0); run(2 * PER, 0);
    req = "R7";  set_f(1, 1, 1, 1, 1); run(2 * PER, 0);
    req = "R8";
    for (int k = 0; k < 12; k++) begin
      set_f(k[0], k[1], k[2], (k % 5) == 4, 1'b0);
      run(7 + (k % 4) * 3, 0);
    end
    req = "R2";  set_f(0, 0, 0, 0, 0); run(2 * PER, 0);
    req = "R9";  set_f(1, 0, 0, 0, 0); run(4 * PER, 1);
    req = "R9";  run(PER + 5, 2);
    req = "R9";  set_f(0, 1, 0, 0, 0); run(3 * PER, 1);
    req = "R9";  run(3 * PER, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule